// File: doc/BRIEF.md
# Register Renamer with Shared Result Queue

This block renames one instruction per cycle for an out-of-order core. It keeps two mapping tables, one for the general-purpose register class and one for the extended (vector) class. Each table entry either names a slot in a single shared result queue or says that the register's value sits in the architectural register file. The result queue is a circular buffer of speculative results. A new destination always takes the slot at the queue's allocation end. Slots return to the pool when the oldest entry retires or when the whole speculative window is flushed.

Each cycle a front end presents a class bit, a destination number with a valid bit, and two source numbers. The block answers in the same cycle with the destination's queue tag and, for each source, either a queue tag or the architectural indication. A destination mapping is staged for one cycle before it reaches the table array. A bypass comparator gives the next instruction's sources the staged mapping, so a dependent instruction renamed right behind its producer already sees the new tag. When every queue slot is taken, the block raises a stall and ignores rename requests.

Top module: `rename_core`

## Requirements
- R1: After reset every register of both classes reads as architectural, the stall output is low and the first destination tag offered is 0.
- R2: The destination tag output always equals the queue allocation slot. Each accepted rename with a valid destination advances it by one, modulo 32. A request without a valid destination, or with the valid input low, does not advance it.
- R3: A source lookup returns queued=1 with the tag of the latest destination renamed to that register of that class in an earlier cycle. If no such mapping is live, it returns queued=0.
- R4: A source that names the destination renamed in the immediately preceding cycle receives that new tag with no gap cycle. A source that names its own instruction's destination receives the mapping that was in force before this instruction.
- R5: The class bit selects the table: 0 means general-purpose (16 registers), 1 means extended (32 registers). A rename in one class never alters lookups in the other class.
- R6: The stall output is high exactly while 32 slots are outstanding. A rename request made while stalled has no effect on the tags or the mappings.
- R7: A retire request frees the oldest outstanding slot, one per cycle. A retire request while the queue is empty is ignored.
- R8: On retire, a register whose mapping still names the retiring slot becomes architectural. A register that has since been renamed to a newer slot keeps that newer mapping.
- R9: A flush makes every register of both classes architectural and empties the queue, so the next destination tag equals the oldest outstanding slot. In the same cycle a flush overrides any rename or retire request.
- R10: If the slot just assigned in the preceding cycle retires while its mapping is still staged, that register ends up architectural.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | Rename request present this cycle |
| renClass | input | 1 | Register class: 0 general-purpose, 1 extended |
| renDstValid | input | 1 | Instruction writes a destination register |
| renDst | input | 5 | Destination register number |
| renSrcA | input | 5 | First source register number |
| renSrcB | input | 5 | Second source register number |
| retValid | input | 1 | Retire the oldest outstanding slot |
| flushValid | input | 1 | Discard the whole speculative window |
| renStall | output | 1 | Queue full; rename requests are ignored |
| rspDstTag | output | 5 | Queue slot assigned to the destination |
| rspSrcAQueued | output | 1 | First source maps to a queue slot |
| rspSrcATag | output | 5 | Queue slot of the first source |
| rspSrcBQueued | output | 1 | Second source maps to a queue slot |
| rspSrcBTag | output | 5 | Queue slot of the second source |

## Verification
The assertions assume that a general-purpose register number on the request and source inputs is below 16 whenever the class bit selects that table. The bench draws general-purpose numbers modulo 16 and extended numbers modulo 32, so it never leaves that range. The assertions also allow retire and flush at any time, including while empty or full. The stimulus covers those cases deliberately, both in directed sequences and through a long pseudo-random stream whose phases narrow the register set to force bypass hits and hold back retires to fill the queue.

// File: rtl/rename_pkg.sv
package rename_pkg;

  localparam logic CLS_GP  = 1'b0;
  localparam logic CLS_EXT = 1'b1;

  // Strobes from the queue control to the mapping datapath.
  typedef struct packed {
    logic alloc;   // a destination takes the allocation slot this cycle
    logic retire;  // the oldest slot leaves the queue this cycle
    logic flush;   // speculative window discarded this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/rename_queue_ctrl.sv
module rename_queue_ctrl
  import rename_pkg::*;
#(
  parameter int QDEPTH = 32,
  parameter int TAG_W  = $clog2(QDEPTH),
  parameter int PTR_W  = TAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             renValid,
  input  logic             renDstValid,
  input  logic             retValid,
  input  logic             flushValid,
  output logic             renStall,
  output logic [TAG_W-1:0] allocTag,
  output logic [TAG_W-1:0] retireTag,
  output ctrlStrobes_t     strobes
);

  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] occupancy;
  logic             qFull;
  logic             qEmpty;

  assign occupancy = tailPtr - headPtr;
  assign qFull     = (occupancy == PTR_W'(QDEPTH));
  assign qEmpty    = (occupancy == '0);

  assign renStall  = qFull;
  assign allocTag  = tailPtr[TAG_W-1:0];
  assign retireTag = headPtr[TAG_W-1:0];

  always_comb begin
    strobes        = '0;
    strobes.flush  = flushValid;
    strobes.alloc  = renValid && renDstValid && !qFull && !flushValid;
    strobes.retire = retValid && !qEmpty && !flushValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (strobes.flush) begin
      tailPtr <= headPtr;
    end else begin
      if (strobes.alloc)  tailPtr <= tailPtr + 1'b1;
      if (strobes.retire) headPtr <= headPtr + 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (renStall && !flushValid) |=> (tailPtr == $past(tailPtr))); // R6

  AST_TAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.alloc |=> (allocTag == TAG_W'($past(allocTag) + 1'b1))); // R2

  AST_EMPTY_RETIRE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (retValid && (headPtr == tailPtr)) |=> (headPtr == $past(headPtr))); // R7

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flushValid |=> ((tailPtr == headPtr) && !renStall)); // R9

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NREGS = 16,
  parameter int IDX_W = $clog2(NREGS),
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clearAll,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrQueued,
  input  logic [TAG_W-1:0] wrTag,
  input  logic             clrEn,
  input  logic [TAG_W-1:0] clrTag,
  input  logic [IDX_W-1:0] rdIdxA,
  input  logic [IDX_W-1:0] rdIdxB,
  output logic             rdQueuedA,
  output logic [TAG_W-1:0] rdTagA,
  output logic             rdQueuedB,
  output logic [TAG_W-1:0] rdTagB
);

  logic [NREGS-1:0] queued;
  logic [TAG_W-1:0] tagMem [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : gEntry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        queued[i] <= 1'b0;
        tagMem[i] <= '0;
      end else if (clearAll) begin
        queued[i] <= 1'b0;
      end else if (wrEn && (wrIdx == IDX_W'(i))) begin
        queued[i] <= wrQueued;
        tagMem[i] <= wrTag;
      end else if (clrEn && queued[i] && (tagMem[i] == clrTag)) begin
        queued[i] <= 1'b0;
      end
    end
  end

  assign rdQueuedA = queued[rdIdxA];
  assign rdTagA    = tagMem[rdIdxA];
  assign rdQueuedB = queued[rdIdxB];
  assign rdTagB    = tagMem[rdIdxB];

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clearAll |=> (queued == '0)); // R9

  AST_RETIRED_READ_ARCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clrEn && !clearAll && !(wrEn && (wrIdx == rdIdxA)) && queued[rdIdxA]
      && (tagMem[rdIdxA] == clrTag)) |=> !queued[$past(rdIdxA)]); // R8

endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int GP_REGS  = 16,
  parameter int EXT_REGS = 32,
  parameter int TAG_W    = 5,
  parameter int REG_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strobes,
  input  logic [TAG_W-1:0] allocTag,
  input  logic [TAG_W-1:0] retireTag,
  input  logic             renValid,
  input  logic             renClass,
  input  logic [REG_W-1:0] renDst,
  input  logic [REG_W-1:0] renSrcA,
  input  logic [REG_W-1:0] renSrcB,
  output logic             rspSrcAQueued,
  output logic [TAG_W-1:0] rspSrcATag,
  output logic             rspSrcBQueued,
  output logic [TAG_W-1:0] rspSrcBTag
);

  localparam int GP_IDX_W  = $clog2(GP_REGS);
  localparam int EXT_IDX_W = $clog2(EXT_REGS);

  // Staged destination mapping: written to the array one edge later.
  logic             stgValid;
  logic             stgClass;
  logic [REG_W-1:0] stgIdx;
  logic [TAG_W-1:0] stgTag;
  logic             commitQueued;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stgValid <= 1'b0;
      stgClass <= CLS_GP;
      stgIdx   <= '0;
      stgTag   <= '0;
    end else if (strobes.flush) begin
      stgValid <= 1'b0;
    end else begin
      stgValid <= strobes.alloc;
      if (strobes.alloc) begin
        stgClass <= renClass;
        stgIdx   <= renDst;
        stgTag   <= allocTag;
      end
    end
  end

  // A staged slot that retires before it lands becomes architectural.
  assign commitQueued = !(strobes.retire && (retireTag == stgTag));

  logic [1:0]       tblQueuedA;
  logic [1:0]       tblQueuedB;
  logic [TAG_W-1:0] tblTagA [2];
  logic [TAG_W-1:0] tblTagB [2];

  for (genvar g = 0; g < 2; g++) begin : gTable
    localparam int NR = (g == 0) ? GP_REGS : EXT_REGS;
    localparam int IW = (g == 0) ? GP_IDX_W : EXT_IDX_W;

    rename_map_table #(
      .NREGS (NR),
      .IDX_W (IW),
      .TAG_W (TAG_W)
    ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .clearAll  (strobes.flush),
      .wrEn      (stgValid && (stgClass == 1'(g))),
      .wrIdx     (stgIdx[IW-1:0]),
      .wrQueued  (commitQueued),
      .wrTag     (stgTag),
      .clrEn     (strobes.retire),
      .clrTag    (retireTag),
      .rdIdxA    (renSrcA[IW-1:0]),
      .rdIdxB    (renSrcB[IW-1:0]),
      .rdQueuedA (tblQueuedA[g]),
      .rdTagA    (tblTagA[g]),
      .rdQueuedB (tblQueuedB[g]),
      .rdTagB    (tblTagB[g])
    );
  end

  logic bypassA;
  logic bypassB;

  assign bypassA = stgValid && (stgClass == renClass) && (stgIdx == renSrcA);
  assign bypassB = stgValid && (stgClass == renClass) && (stgIdx == renSrcB);

  assign rspSrcAQueued = bypassA || tblQueuedA[renClass];
  assign rspSrcATag    = bypassA ? stgTag : tblTagA[renClass];
  assign rspSrcBQueued = bypassB || tblQueuedB[renClass];
  assign rspSrcBTag    = bypassB ? stgTag : tblTagB[renClass];

  AST_GP_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (renValid && (renClass == CLS_GP)) |->
      ((int'(renDst) < GP_REGS) && (int'(renSrcA) < GP_REGS) && (int'(renSrcB) < GP_REGS))); // R5

  AST_STAGE_FOLLOWS_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.alloc |=> (stgValid && (stgTag == $past(allocTag)))); // R2

  AST_STAGE_DROPPED_ON_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.flush |=> !stgValid); // R9

  AST_BYPASS_SEES_NEW_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.alloc && !strobes.flush) |=>
      ((stgClass != renClass) || (stgIdx != renSrcA) || (rspSrcAQueued && (rspSrcATag == $past(allocTag))))); // R4

endmodule

// File: rtl/rename_core.sv
module rename_core
  import rename_pkg::*;
#(
  parameter  int GP_REGS  = 16,
  parameter  int EXT_REGS = 32,
  parameter  int QDEPTH   = 32,
  localparam int TAG_W    = $clog2(QDEPTH),
  localparam int REG_W    = (EXT_REGS > GP_REGS) ? $clog2(EXT_REGS) : $clog2(GP_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             renValid,
  input  logic             renClass,
  input  logic             renDstValid,
  input  logic [REG_W-1:0] renDst,
  input  logic [REG_W-1:0] renSrcA,
  input  logic [REG_W-1:0] renSrcB,
  input  logic             retValid,
  input  logic             flushValid,
  output logic             renStall,
  output logic [TAG_W-1:0] rspDstTag,
  output logic             rspSrcAQueued,
  output logic [TAG_W-1:0] rspSrcATag,
  output logic             rspSrcBQueued,
  output logic [TAG_W-1:0] rspSrcBTag
);

  ctrlStrobes_t     strobes;
  logic [TAG_W-1:0] allocTag;
  logic [TAG_W-1:0] retireTag;

  rename_queue_ctrl #(
    .QDEPTH (QDEPTH),
    .TAG_W  (TAG_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .renValid    (renValid),
    .renDstValid (renDstValid),
    .retValid    (retValid),
    .flushValid  (flushValid),
    .renStall    (renStall),
    .allocTag    (allocTag),
    .retireTag   (retireTag),
    .strobes     (strobes)
  );

  rename_datapath #(
    .GP_REGS  (GP_REGS),
    .EXT_REGS (EXT_REGS),
    .TAG_W    (TAG_W),
    .REG_W    (REG_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .strobes       (strobes),
    .allocTag      (allocTag),
    .retireTag     (retireTag),
    .renValid      (renValid),
    .renClass      (renClass),
    .renDst        (renDst),
    .renSrcA       (renSrcA),
    .renSrcB       (renSrcB),
    .rspSrcAQueued (rspSrcAQueued),
    .rspSrcATag    (rspSrcATag),
    .rspSrcBQueued (rspSrcBQueued),
    .rspSrcBTag    (rspSrcBTag)
  );

  assign rspDstTag = allocTag;

endmodule

// File: tb/rename_core_tb.sv
module rename_core_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       renValid = 1'b0;
  logic       renClass = 1'b0;
  logic       renDstValid = 1'b0;
  logic [4:0] renDst = '0;
  logic [4:0] renSrcA = '0;
  logic [4:0] renSrcB = '0;
  logic       retValid = 1'b0;
  logic       flushValid = 1'b0;
  logic       renStall;
  logic [4:0] rspDstTag;
  logic       rspSrcAQueued;
  logic [4:0] rspSrcATag;
  logic       rspSrcBQueued;
  logic [4:0] rspSrcBTag;

  always #2.5 clk = ~clk;

  rename_core u_dut (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renClass(renClass),
    .renDstValid(renDstValid), .renDst(renDst), .renSrcA(renSrcA), .renSrcB(renSrcB),
    .retValid(retValid), .flushValid(flushValid), .renStall(renStall),
    .rspDstTag(rspDstTag), .rspSrcAQueued(rspSrcAQueued), .rspSrcATag(rspSrcATag),
    .rspSrcBQueued(rspSrcBQueued), .rspSrcBTag(rspSrcBTag)
  );

  // Reference state: -1 means architectural, otherwise a slot number.
  int gpMap [16];
  int extMap [32];
  int head = 0;
  int tail = 0;
  int nChecks = 0;
  int nErrors = 0;
  bit done = 0;
  int rng = 32'h1234_5678;

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int mapOf(input logic cls, input int r);
    return cls ? extMap[r % 32] : gpMap[r % 16];
  endfunction

  task automatic checkLookup(input string req);
    chk(req, "srcA", rspSrcAQueued ? int'(rspSrcATag) : -1, mapOf(renClass, int'(renSrcA)));
    chk(req, "srcB", rspSrcBQueued ? int'(rspSrcBTag) : -1, mapOf(renClass, int'(renSrcB)));
  endtask

  task automatic clearModel();
    for (int i = 0; i < 16; i++) gpMap[i] = -1;
    for (int i = 0; i < 32; i++) extMap[i] = -1;
  endtask

  // One cycle: drive at the falling edge, check, then update the model at the rising edge.
  task automatic step(input logic v, input logic cls, input logic dv, input int d,
                      input int a, input int b, input logic ret, input logic fl,
                      input string req);
    int cnt;
    @(negedge clk);
    renValid = v; renClass = cls; renDstValid = dv;
    renDst = 5'(d); renSrcA = 5'(a); renSrcB = 5'(b);
    retValid = ret; flushValid = fl;
    #1;
    cnt = tail - head;
    chk("R6", "stall", int'(renStall), (cnt == 32) ? 1 : 0);
    chk("R2", "dstTag", int'(rspDstTag), tail % 32);
    checkLookup(req);
    @(posedge clk);
    if (fl) begin
      clearModel();
      tail = head;
    end else begin
      if (ret && cnt > 0) begin
        for (int i = 0; i < 16; i++) if (gpMap[i] == head % 32) gpMap[i] = -1;
        for (int i = 0; i < 32; i++) if (extMap[i] == head % 32) extMap[i] = -1;
        head++;
      end
      if (v && dv && cnt < 32) begin
        if (cls) extMap[d % 32] = tail % 32;
        else gpMap[d % 16] = tail % 32;
        tail++;
      end
    end
  endtask

  task automatic probe(input logic cls, input int r, input string req);
    @(negedge clk);
    renValid = 0; renDstValid = 0; retValid = 0; flushValid = 0;
    renClass = cls; renSrcA = 5'(r); renSrcB = 5'(r);
    #1;
    checkLookup(req);
  endtask

  function automatic int nextRnd();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >>> 17);
    rng = rng ^ (rng << 5);
    return rng & 32'h7fff_ffff;
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      nErrors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    clearModel();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1;
    chk("R1", "stall", int'(renStall), 0);
    chk("R1", "dstTag", int'(rspDstTag), 0);
    for (int r = 0; r < 16; r++) probe(1'b0, r, "R1");
    for (int r = 0; r < 32; r++) probe(1'b1, r, "R1");

    // R5 / R4: rename GP r3, other class untouched, bypass then array path
    step(1, 0, 1, 3, 0, 1, 0, 0, "R3");
    probe(1'b0, 3, "R4");   // staged mapping via bypass
    probe(1'b1, 3, "R5");   // extended r3 still architectural
    probe(1'b0, 3, "R3");   // array path
    // R4: own destination as a source sees the older mapping
    step(1, 0, 1, 3, 3, 3, 0, 0, "R4");
    // R4: back-to-back dependent instruction
    step(1, 0, 1, 4, 3, 2, 0, 0, "R4");
    step(1, 1, 1, 3, 3, 4, 0, 0, "R5");
    probe(1'b0, 3, "R5");
    probe(1'b1, 3, "R5");
    // R2: no destination, no advance
    step(1, 0, 0, 5, 4, 3, 0, 0, "R2");
    step(0, 1, 1, 6, 3, 3, 0, 0, "R2");
    // R8: retire slot 0 (GP r3 remapped to 1, unaffected), then slot 1
    step(0, 0, 0, 0, 3, 4, 1, 0, "R8");
    probe(1'b0, 3, "R8");
    step(0, 0, 0, 0, 3, 4, 1, 0, "R8");
    probe(1'b0, 3, "R8");
    probe(1'b0, 4, "R8");
    // R9: flush overrides a rename and a retire in the same cycle
    step(1, 0, 1, 7, 4, 3, 1, 1, "R9");
    probe(1'b0, 4, "R9");
    probe(1'b1, 3, "R9");
    probe(1'b0, 7, "R9");
    // R7: retire while empty is ignored
    step(0, 0, 0, 0, 0, 0, 1, 0, "R7");
    step(1, 1, 1, 9, 9, 0, 0, 0, "R7");
    // R10: retire the slot while its mapping is still staged
    step(0, 1, 0, 0, 9, 9, 1, 0, "R10");
    probe(1'b1, 9, "R10");
    // R6: fill to 32 outstanding, then a stalled rename has no effect
    for (int i = 0; i < 32; i++) step(1, i[0], 1, i % 16, i % 16, (i + 1) % 16, 0, 0, "R3");
    step(1, 1, 1, 20, 20, 0, 0, 0, "R6");
    probe(1'b1, 20, "R6");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R7");
    step(1, 1, 1, 20, 20, 1, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R9");

    // Pseudo-random sweep in phases
    for (int ph = 0; ph < 4; ph++) begin
      for (int n = 0; n < 3000; n++) begin
        int x = nextRnd();
        logic cls = x[0];
        int span = (ph == 1) ? 3 : (cls ? 32 : 16);
        int d = (x >> 1) % span;
        int a = (x >> 7) % span;
        int b = (x >> 13) % span;
        logic v = ((x >> 19) % 8) < 6;
        logic dv = ((x >> 22) % 4) != 0;
        logic ret = (ph == 2) ? (((x >> 24) % 8) == 0) : (((x >> 24) % 8) < 4);
        logic fl = ((x >> 27) % 64) == 0 && ph != 2;
        step(v, cls, dv, d, a, b, ret, fl, "R3");
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule